// File: doc/BRIEF.md
# Test-Mode Instruction Injection Multiplexer

This block sits between the fetch path of a small nibble-wide CPU, its byte-wide program ROM, and two external test pins. The two pins are synchronised and decoded into four mutually exclusive modes: one normal mode and three test modes. In the injection mode, the opcode bytes handed to the CPU are assembled from two nibbles taken on consecutive clock edges from the 4-bit input port, and the ROM is bypassed. The two observation modes replace the normal output-port data with the accumulator or with one selected nibble of the program counter.

The fetch source is chosen separately for each byte. A new mode is adopted only while no byte is being assembled. This lets test equipment splice a single injected byte into an otherwise ROM-fed instruction stream. For example, it can supply the opcode byte of a two-byte jump from the port and let the target byte come from the ROM. The output port drives only the bits that the direction register marks as outputs. After reset the CPU leaves all bits as inputs, so observation stays hidden until software sets the direction bits.

Top module: `tmode_inject_mux`

## Requirements
- R1: The synchronised pin pair {test_pins[1], test_pins[0]} selects exactly one mode: 00 normal, 01 injection, 10 accumulator observation, 11 program-counter observation.
- R2: Reset selects normal mode whatever the pins show. While no byte is being assembled, a pin change takes effect on the third rising clock edge after it.
- R3: In normal and observation modes, a fetch_req sampled on an edge while idle gives fetch_ack high after that edge, with fetch_byte equal to rom_byte as sampled on that edge.
- R4: In injection mode, the edge that accepts fetch_req captures in_nib as bits 7:4. The next edge captures in_nib as bits 3:0 and raises fetch_ack. rom_byte has no effect on the result.
- R5: fetch_ack is high for one cycle per accepted fetch. A fetch_req seen while the low nibble is pending starts no new fetch.
- R6: The mode is frozen while a byte is being assembled. An injected byte that has started completes from the port even if the pins return to 00.
- R7: Consecutive bytes can come from different sources: an injected byte, then a ROM byte after the pins change to normal.
- R8: In accumulator observation, out_port equals acc_tap masked by port_dir.
- R9: In program-counter observation, pc_nib_sel values 0, 1 and 2 show pc_tap bits 3:0, 7:4 and 11:8. Value 3 shows zero. The value is masked by port_dir.
- R10: out_en equals port_dir, and out_port is zero on every bit whose direction bit is 0. In normal and injection modes, out_port shows port_data masked by port_dir.
- R11: During and right after reset, fetch_ack and fetch_byte are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| test_pins | input | 2 | Asynchronous test-mode pins |
| in_nib | input | 4 | Input port nibble used for injection |
| rom_byte | input | 8 | Byte read from program ROM |
| fetch_req | input | 1 | CPU requests one instruction byte |
| fetch_ack | output | 1 | One-cycle pulse: fetch_byte is valid |
| fetch_byte | output | 8 | Instruction byte delivered to the CPU |
| acc_tap | input | 4 | Accumulator value |
| pc_tap | input | 12 | Program counter value |
| pc_nib_sel | input | 2 | Selects the observed PC nibble |
| port_data | input | 4 | Normal output-port register |
| port_dir | input | 4 | Direction bits, 1 = output |
| out_port | output | 4 | Output port data |
| out_en | output | 4 | Per-bit output drive enable |

## Verification
The results arrive with different delays:
- A pin change reaches the active mode on the third rising edge.
- A ROM-sourced byte is acknowledged one edge after its request.
- An injected byte is acknowledged two edges after its request.
- The observation output follows the active mode and its taps in the same cycle.

The bench drives all inputs and samples all outputs on the falling edge. It waits the exact number of rising edges that each path needs before it compares. The pin-latency check samples on both sides of the third edge. The freeze check moves the pins in the cycle a byte begins, so the byte still completes from the port.

// File: rtl/tmx_pkg.sv
package tmx_pkg;

    localparam int NIB_W  = 4;
    localparam int MODE_N = 4;

    typedef enum logic [1:0] {
        MODE_NORMAL  = 2'b00,
        MODE_INJECT  = 2'b01,
        MODE_OBS_ACC = 2'b10,
        MODE_OBS_PC  = 2'b11
    } tmode_e;

    typedef enum logic {
        FS_IDLE    = 1'b0,
        FS_WAIT_LO = 1'b1
    } fstate_e;

    // One AND term per pin combination, built from true and inverted pins.
    function automatic logic [MODE_N-1:0] pins_to_onehot(input logic [1:0] pins);
        logic [1:0] inv;
        logic [MODE_N-1:0] res;
        inv    = ~pins;
        res[0] = inv[1]  & inv[0];
        res[1] = inv[1]  & pins[0];
        res[2] = pins[1] & inv[0];
        res[3] = pins[1] & pins[0];
        return res;
    endfunction

endpackage

// File: rtl/tmx_mode_sync.sv
module tmx_mode_sync
    import tmx_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        pins,
    input  logic              load_en,
    output logic [MODE_N-1:0] mode_oh
);

    logic [1:0] chain [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) chain[i] <= '0;
        end else begin
            chain[0] <= pins;
            for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
        end
    end

    // Mode register is loaded only at a fetch boundary.
    always_ff @(posedge clk) begin
        if (rst)          mode_oh <= MODE_N'(1) << int'(MODE_NORMAL);
        else if (load_en) mode_oh <= pins_to_onehot(chain[STAGES-1]);
    end

    p_mode_onehot_r1: assert property (@(posedge clk) disable iff (rst)
        $onehot(mode_oh));

endmodule

// File: rtl/tmx_fetch_splice.sv
module tmx_fetch_splice
    import tmx_pkg::*;
#(
    parameter int NW = NIB_W
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            inject,
    input  logic            fetch_req,
    input  logic [NW-1:0]   in_nib,
    input  logic [2*NW-1:0] rom_byte,
    output logic            fetch_ack,
    output logic [2*NW-1:0] fetch_byte,
    output logic            idle
);

    localparam int BW = 2 * NW;

    fstate_e       state_q;
    logic [NW-1:0] hi_q;
    logic          ack_q;
    logic [BW-1:0] byte_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= FS_IDLE;
            hi_q    <= '0;
            ack_q   <= 1'b0;
            byte_q  <= '0;
        end else begin
            ack_q <= 1'b0;
            case (state_q)
                FS_IDLE: begin
                    if (fetch_req) begin
                        if (inject) begin
                            hi_q    <= in_nib;
                            state_q <= FS_WAIT_LO;
                        end else begin
                            byte_q <= rom_byte;
                            ack_q  <= 1'b1;
                        end
                    end
                end
                FS_WAIT_LO: begin
                    byte_q  <= {hi_q, in_nib};
                    ack_q   <= 1'b1;
                    state_q <= FS_IDLE;
                end
                default: state_q <= FS_IDLE;
            endcase
        end
    end

    assign fetch_ack  = ack_q;
    assign fetch_byte = byte_q;
    assign idle       = (state_q == FS_IDLE);

    p_lo_ack_r4: assert property (@(posedge clk) disable iff (rst)
        (state_q == FS_WAIT_LO) |=> fetch_ack);

    p_hi_nib_r4: assert property (@(posedge clk) disable iff (rst)
        (state_q == FS_WAIT_LO) |=> (fetch_byte[BW-1:NW] == $past(in_nib, 2)));

    p_rom_ack_r3: assert property (@(posedge clk) disable iff (rst)
        (state_q == FS_IDLE && fetch_req && !inject)
            |=> (fetch_ack && fetch_byte == $past(rom_byte)));

endmodule

// File: rtl/tmx_port_observe.sv
module tmx_port_observe
    import tmx_pkg::*;
#(
    parameter int NW    = NIB_W,
    parameter int PC_W  = 12,
    parameter int SEL_W = 2
) (
    input  logic [MODE_N-1:0] mode_oh,
    input  logic [NW-1:0]     acc_tap,
    input  logic [PC_W-1:0]   pc_tap,
    input  logic [SEL_W-1:0]  pc_sel,
    input  logic [NW-1:0]     port_data,
    input  logic [NW-1:0]     port_dir,
    output logic [NW-1:0]     out_port,
    output logic [NW-1:0]     out_en
);

    localparam int PC_NIBS = PC_W / NW;

    logic [NW-1:0] pc_slice [PC_NIBS];
    logic [NW-1:0] pc_pick;
    logic [NW-1:0] source;

    for (genvar g = 0; g < PC_NIBS; g++) begin : g_pc_slice
        assign pc_slice[g] = pc_tap[g*NW +: NW];
    end

    always_comb begin
        pc_pick = '0;
        for (int i = 0; i < PC_NIBS; i++) begin
            if (pc_sel == SEL_W'(i)) pc_pick = pc_slice[i];
        end
    end

    always_comb begin
        if (mode_oh[int'(MODE_OBS_ACC)])     source = acc_tap;
        else if (mode_oh[int'(MODE_OBS_PC)]) source = pc_pick;
        else                                 source = port_data;
    end

    assign out_port = source & port_dir;
    assign out_en   = port_dir;

endmodule

// File: rtl/tmode_inject_mux.sv
module tmode_inject_mux
    import tmx_pkg::*;
#(
    parameter  int PC_W        = 12,
    parameter  int SYNC_STAGES = 2,
    localparam int SEL_W       = $clog2(PC_W / NIB_W)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [1:0]         test_pins,
    input  logic [NIB_W-1:0]   in_nib,
    input  logic [2*NIB_W-1:0] rom_byte,
    input  logic               fetch_req,
    output logic               fetch_ack,
    output logic [2*NIB_W-1:0] fetch_byte,
    input  logic [NIB_W-1:0]   acc_tap,
    input  logic [PC_W-1:0]    pc_tap,
    input  logic [SEL_W-1:0]   pc_nib_sel,
    input  logic [NIB_W-1:0]   port_data,
    input  logic [NIB_W-1:0]   port_dir,
    output logic [NIB_W-1:0]   out_port,
    output logic [NIB_W-1:0]   out_en
);

    logic [MODE_N-1:0] mode_oh;
    logic              fetch_idle;

    tmx_mode_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .pins    (test_pins),
        .load_en (fetch_idle),
        .mode_oh (mode_oh)
    );

    tmx_fetch_splice #(.NW(NIB_W)) u_fetch (
        .clk        (clk),
        .rst        (rst),
        .inject     (mode_oh[int'(MODE_INJECT)]),
        .fetch_req  (fetch_req),
        .in_nib     (in_nib),
        .rom_byte   (rom_byte),
        .fetch_ack  (fetch_ack),
        .fetch_byte (fetch_byte),
        .idle       (fetch_idle)
    );

    tmx_port_observe #(.NW(NIB_W), .PC_W(PC_W), .SEL_W(SEL_W)) u_obs (
        .mode_oh   (mode_oh),
        .acc_tap   (acc_tap),
        .pc_tap    (pc_tap),
        .pc_sel    (pc_nib_sel),
        .port_data (port_data),
        .port_dir  (port_dir),
        .out_port  (out_port),
        .out_en    (out_en)
    );

    p_freeze_r6: assert property (@(posedge clk) disable iff (rst)
        !fetch_idle |=> $stable(mode_oh));

    p_acc_obs_r8: assert property (@(posedge clk) disable iff (rst)
        mode_oh[int'(MODE_OBS_ACC)] |-> (out_port == (acc_tap & port_dir)));

    p_pc_obs_r9: assert property (@(posedge clk) disable iff (rst)
        (mode_oh[int'(MODE_OBS_PC)] && pc_nib_sel == '0)
            |-> (out_port == (pc_tap[NIB_W-1:0] & port_dir)));

    p_dir_mask_r10: assert property (@(posedge clk) disable iff (rst)
        (out_port & ~out_en) == '0);

endmodule

// File: tb/tmode_inject_mux_bench.sv
`timescale 1ns/1ps
module tmode_inject_mux_bench;

    logic        clk = 1'b0;
    logic        rst;
    logic [1:0]  test_pins;
    logic [3:0]  in_nib;
    logic [7:0]  rom_byte;
    logic        fetch_req;
    logic        fetch_ack;
    logic [7:0]  fetch_byte;
    logic [3:0]  acc_tap;
    logic [11:0] pc_tap;
    logic [1:0]  pc_nib_sel;
    logic [3:0]  port_data;
    logic [3:0]  port_dir;
    logic [3:0]  out_port;
    logic [3:0]  out_en;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    tmode_inject_mux u_tmode_inject_mux (
        .clk(clk), .rst(rst), .test_pins(test_pins), .in_nib(in_nib),
        .rom_byte(rom_byte), .fetch_req(fetch_req), .fetch_ack(fetch_ack),
        .fetch_byte(fetch_byte), .acc_tap(acc_tap), .pc_tap(pc_tap),
        .pc_nib_sel(pc_nib_sel), .port_data(port_data), .port_dir(port_dir),
        .out_port(out_port), .out_en(out_en)
    );

    typedef struct packed {
        logic [1:0]  mode;
        logic [3:0]  hi;
        logic [3:0]  lo;
        logic [7:0]  rom;
        logic [3:0]  dir;
        logic [3:0]  preg;
        logic [3:0]  acc;
        logic [11:0] pc;
        logic [1:0]  sel;
        logic [7:0]  exp_byte;
        logic [3:0]  exp_out;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 4'h3, 4'hC, 8'hA5, 4'hF, 4'h6, 4'h9, 12'h123, 2'd0, 8'hA5, 4'h6},
        '{2'd1, 4'h7, 4'h7, 8'h00, 4'hF, 4'h6, 4'h9, 12'h123, 2'd0, 8'h77, 4'h6},
        '{2'd2, 4'h0, 4'h0, 8'h3C, 4'hF, 4'h6, 4'h9, 12'h123, 2'd0, 8'h3C, 4'h9},
        '{2'd3, 4'h0, 4'h0, 8'h81, 4'hF, 4'h6, 4'h9, 12'hABC, 2'd0, 8'h81, 4'hC},
        '{2'd3, 4'h0, 4'h0, 8'h18, 4'hF, 4'h6, 4'h9, 12'hABC, 2'd1, 8'h18, 4'hB},
        '{2'd3, 4'h0, 4'h0, 8'hFF, 4'hF, 4'h6, 4'h9, 12'hABC, 2'd2, 8'hFF, 4'hA},
        '{2'd3, 4'h0, 4'h0, 8'h5E, 4'hF, 4'h6, 4'h9, 12'hABC, 2'd3, 8'h5E, 4'h0},
        '{2'd2, 4'h0, 4'h0, 8'h42, 4'h0, 4'h6, 4'h9, 12'hABC, 2'd0, 8'h42, 4'h0},
        '{2'd2, 4'h0, 4'h0, 8'h24, 4'h5, 4'h6, 4'hF, 12'hABC, 2'd0, 8'h24, 4'h5},
        '{2'd1, 4'h7, 4'h6, 8'h11, 4'h3, 4'hE, 4'h9, 12'hABC, 2'd0, 8'h76, 4'h2}
    };

    task automatic chk(input string tag, input logic [11:0] act, input logic [11:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // ROM-sourced fetch: acknowledged one edge after the request.
    task automatic rom_fetch(input logic [7:0] b);
        rom_byte  = b;
        fetch_req = 1'b1;
        @(negedge clk);
        fetch_req = 1'b0;
    endtask

    // Injected fetch: high nibble on the accepting edge, low nibble on the next.
    task automatic inj_fetch(input logic [3:0] h, input logic [3:0] l);
        in_nib    = h;
        fetch_req = 1'b1;
        @(negedge clk);
        fetch_req = 1'b0;
        in_nib    = l;
        @(negedge clk);
    endtask

    task automatic set_mode(input logic [1:0] m);
        test_pins = m;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        rst = 1'b1; test_pins = 2'b10; in_nib = '0; rom_byte = '0;
        fetch_req = 1'b0; acc_tap = 4'h9; pc_tap = 12'h123; pc_nib_sel = '0;
        port_data = 4'h6; port_dir = 4'hF;

        // R11 / R2: reset state with pins already at a test code.
        repeat (3) @(negedge clk);
        chk("R11 ack in reset", 12'(fetch_ack), 12'h0);
        chk("R11 byte in reset", 12'(fetch_byte), 12'h0);
        chk("R2 normal in reset", 12'(out_port), 12'h6);
        rst = 1'b0;
        @(negedge clk);
        chk("R11 ack after reset", 12'(fetch_ack), 12'h0);
        @(negedge clk);
        chk("R2 mode not yet after two edges", 12'(out_port), 12'h6);
        @(negedge clk);
        chk("R2 mode on third edge", 12'(out_port), 12'h9);

        // Table of mode, observation and fetch vectors (R1, R3, R4, R8, R9, R10).
        for (int i = 0; i < NV; i++) begin
            set_mode(VECS[i].mode);
            port_dir   = VECS[i].dir;
            port_data  = VECS[i].preg;
            acc_tap    = VECS[i].acc;
            pc_tap     = VECS[i].pc;
            pc_nib_sel = VECS[i].sel;
            #1;
            chk($sformatf("R1 R8 R9 R10 out_port vec %0d", i), 12'(out_port), 12'(VECS[i].exp_out));
            chk($sformatf("R10 out_en vec %0d", i), 12'(out_en), 12'(VECS[i].dir));
            if (VECS[i].mode == 2'd1) begin
                rom_byte = VECS[i].rom;
                inj_fetch(VECS[i].hi, VECS[i].lo);
                chk($sformatf("R4 ack vec %0d", i), 12'(fetch_ack), 12'h1);
                chk($sformatf("R4 byte vec %0d", i), 12'(fetch_byte), 12'(VECS[i].exp_byte));
            end else begin
                rom_fetch(VECS[i].rom);
                chk($sformatf("R3 ack vec %0d", i), 12'(fetch_ack), 12'h1);
                chk($sformatf("R3 byte vec %0d", i), 12'(fetch_byte), 12'(VECS[i].exp_byte));
            end
            @(negedge clk);
            chk($sformatf("R5 ack drops vec %0d", i), 12'(fetch_ack), 12'h0);
        end

        // R5: a request held during the low-nibble phase starts nothing.
        port_dir = 4'hF;
        set_mode(2'b01);
        in_nib = 4'h1; fetch_req = 1'b1;
        @(negedge clk);
        in_nib = 4'h2;
        @(negedge clk);
        fetch_req = 1'b0;
        chk("R5 ack held req", 12'(fetch_ack), 12'h1);
        chk("R5 byte held req", 12'(fetch_byte), 12'h12);
        @(negedge clk);
        chk("R5 no extra fetch 1", 12'(fetch_ack), 12'h0);
        @(negedge clk);
        chk("R5 no extra fetch 2", 12'(fetch_ack), 12'h0);

        // R6: pins go back to normal as a byte starts; the byte still comes from the port.
        test_pins = 2'b00;
        rom_byte  = 8'hEE;
        inj_fetch(4'h2, 4'hD);
        chk("R6 ack frozen mode", 12'(fetch_ack), 12'h1);
        chk("R6 byte frozen mode", 12'(fetch_byte), 12'h2D);
        @(negedge clk);
        rom_fetch(8'h99);
        chk("R6 normal after boundary", 12'(fetch_byte), 12'h99);

        // R7: jump opcode byte injected, target byte from ROM.
        set_mode(2'b01);
        inj_fetch(4'h4, 4'h0);
        chk("R7 injected opcode byte", 12'(fetch_byte), 12'h40);
        set_mode(2'b00);
        rom_fetch(8'h5A);
        chk("R7 ack rom target", 12'(fetch_ack), 12'h1);
        chk("R7 rom target byte", 12'(fetch_byte), 12'h5A);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule